// File: doc/BRIEF.md
# Parallel Display Bus Master

This block drives a strobe-based parallel bus of the kind used by small display controllers. The bus has a 16-bit data path, an active-low chip select, active-low write and read strobes, and a data/command select line. A host issues a single access with a valid/ready handshake. The access carries a direction flag, a data/command flag and write data. For a read, the block returns the captured bus data together with a one-cycle done pulse. Pad tristating is left to the surrounding logic, so the data path is split into a driven output, a sampled input and an output enable.

Each access passes through the phases idle, setup, strobe, hold and turnaround. The phase lengths are counted in clock cycles. Writes and reads keep separate strobe-low and turnaround lengths, because display controllers typically need far slower reads than writes. An extra recovery count delays the first read strobe after a write, which covers a long read high-time minimum. The strobe is always released one cycle before chip select, so the strobe rises strictly before chip select does.

Top module: `pbus_master`

## Requirements
- R1: While and after reset, with no request, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1, `bus_oe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `bus_cs_n` falls on that same edge and `bus_dc` takes `req_dc`. All timing inputs are sampled on that edge only, so changing them afterwards has no effect on the running access.
- R3: The strobe falls after exactly `cfg_setup`+1 cycles of chip select low. The one exception is a read delayed by R9, which is never shorter than this.
- R4: A write holds `bus_wr_n` low for exactly `cfg_wr_low`+1 cycles. A read holds `bus_rd_n` low for exactly `cfg_rd_low`+1 cycles.
- R5: A strobe is low only while `bus_cs_n` is low, and only the strobe matching the access direction moves. The strobe rises exactly one cycle before `bus_cs_n` rises.
- R6: During a write, `bus_oe` is 1 and `bus_dout` equals the request's write data in every cycle that `bus_cs_n` is low. `bus_oe` is 0 throughout a read and whenever `bus_cs_n` is high.
- R7: `rsp_done` is 1 for exactly the first cycle in which `bus_cs_n` is high again after an access, and 0 otherwise. For a read, `rsp_rdata` in that cycle equals `bus_din` as sampled on the rising edge that releases `bus_rd_n`.
- R8: After an access ends, chip select stays high for the turnaround count of that access (`cfg_wr_turn` or `cfg_rd_turn`), plus one cycle, before a waiting request starts.
- R9: When a read follows a write, the write strobe is high for at least R+1 cycles before the read strobe falls, where R is the `cfg_rd_recov` sampled with that write. If this delay lengthens the read's setup beyond R3, the gap is exactly R+1 cycles.
- R10: `req_ready` is 0 in every cycle in which `bus_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_rd | input | 1 | 1 = read access, 0 = write access |
| req_dc | input | 1 | Level for the data/command line during the access |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | 4 | Chip-select-to-strobe setup, cycles minus one |
| cfg_wr_low | input | 8 | Write strobe low time, cycles minus one |
| cfg_wr_turn | input | 4 | Chip-select high cycles after a write (plus one) |
| cfg_rd_low | input | 8 | Read strobe low time, cycles minus one |
| cfg_rd_turn | input | 4 | Chip-select high cycles after a read (plus one) |
| cfg_rd_recov | input | 8 | Write-to-read strobe recovery count |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Data/command select |
| bus_dout | output | 16 | Data driven to the pads |
| bus_oe | output | 1 | Pad output enable |
| bus_din | input | 16 | Data sampled from the pads |

## Verification
Chip select falls on the accepting edge. The strobe then follows after setup+1 cycles and stays low for low+1 cycles. Chip select rises one cycle later, and that cycle also carries the done pulse and the read data. The next chip-select fall comes turnaround+1 cycles after that. The bench changes inputs and samples outputs on falling edges only, and counts the phase lengths cycle by cycle against the sampled timing values of each queued request. It also drives junk on the input data path in every strobe cycle except the last, so a capture on the wrong edge shows up as a data mismatch. Write-to-read recovery is checked by counting write-strobe high cycles up to the read strobe fall.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;
endpackage

// File: rtl/pbus_cfg_latch.sv
module pbus_cfg_latch #(
  parameter int SETUP_W = 4,
  parameter int LOW_W   = 8,
  parameter int TURN_W  = 4,
  parameter int RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               req_rd,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [LOW_W-1:0]   cfg_wr_low,
  input  logic [TURN_W-1:0]  cfg_wr_turn,
  input  logic [LOW_W-1:0]   cfg_rd_low,
  input  logic [TURN_W-1:0]  cfg_rd_turn,
  input  logic [RECOV_W-1:0] cfg_rd_recov,
  output logic               rd_q,
  output logic [SETUP_W-1:0] setup_q,
  output logic [LOW_W-1:0]   low_q,
  output logic [TURN_W-1:0]  turn_q,
  output logic [RECOV_W-1:0] recov_q
);
  // Timing is frozen at acceptance; direction picks the read or write budget.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      setup_q <= '0;
      low_q   <= '0;
      turn_q  <= '0;
      recov_q <= '0;
    end else if (accept) begin
      rd_q    <= req_rd;
      setup_q <= cfg_setup;
      low_q   <= req_rd ? cfg_rd_low  : cfg_wr_low;
      turn_q  <= req_rd ? cfg_rd_turn : cfg_wr_turn;
      recov_q <= cfg_rd_recov;
    end
  end
endmodule

// File: rtl/pbus_recov.sv
module pbus_recov #(
  parameter int RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RECOV_W-1:0] load_val,
  output logic               zero
);
  logic [RECOV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - RECOV_W'(1);
  end

  assign zero = (cnt_q == '0);

  // R9: a freshly loaded count is never bypassed in the following cycle
  a_r9_load_blocks: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int LOW_W   = 8,
  parameter int TURN_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               rd_q,
  input  logic               rec_zero,
  input  logic [SETUP_W-1:0] setup_q,
  input  logic [LOW_W-1:0]   low_q,
  input  logic [TURN_W-1:0]  turn_q,
  output phase_e             phase_q,
  output phase_e             phase_d
);
  localparam int CW_A  = (SETUP_W > LOW_W) ? SETUP_W : LOW_W;
  localparam int CNT_W = (CW_A > TURN_W) ? CW_A : TURN_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             at_lim;

  always_comb begin
    case (phase_q)
      PH_SETUP:  lim = CNT_W'(setup_q);
      PH_STROBE: lim = CNT_W'(low_q);
      PH_TURN:   lim = CNT_W'(turn_q) - CNT_W'(1);
      default:   lim = '0;
    endcase
  end

  assign at_lim = (cnt_q == lim);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_SETUP;
          cnt_d   = '0;
        end
      end
      PH_SETUP: begin
        if (at_lim && (!rd_q || rec_zero)) begin
          phase_d = PH_STROBE;
          cnt_d   = '0;
        end else if (!at_lim) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (at_lim) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_HOLD: begin
        phase_d = (turn_q == '0) ? PH_IDLE : PH_TURN;
        cnt_d   = '0;
      end
      PH_TURN: begin
        if (at_lim) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R4: the strobe counter never runs past its sampled limit
  a_r4_strobe_bound: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STROBE) |-> (cnt_q <= CNT_W'(low_q)));

  // R5: hold is a single cycle
  a_r5_hold_single: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD) |=> (phase_q != PH_HOLD));
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SETUP_W = 4,
  parameter int LOW_W   = 8,
  parameter int TURN_W  = 4,
  parameter int RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_rd,
  input  logic               req_dc,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [LOW_W-1:0]   cfg_wr_low,
  input  logic [TURN_W-1:0]  cfg_wr_turn,
  input  logic [LOW_W-1:0]   cfg_rd_low,
  input  logic [TURN_W-1:0]  cfg_rd_turn,
  input  logic [RECOV_W-1:0] cfg_rd_recov,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               bus_cs_n,
  output logic               bus_wr_n,
  output logic               bus_rd_n,
  output logic               bus_dc,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_oe,
  input  logic [DATA_W-1:0]  bus_din
);
  phase_e             phase_q, phase_d;
  logic               accept, rd_q, rec_zero, rec_load, nxt_active, strobe_end;
  logic [SETUP_W-1:0] setup_q;
  logic [LOW_W-1:0]   low_q;
  logic [TURN_W-1:0]  turn_q;
  logic [RECOV_W-1:0] recov_q;

  assign req_ready  = (phase_q == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign nxt_active = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                      (phase_d == PH_HOLD);
  assign strobe_end = (phase_q == PH_STROBE) && (phase_d == PH_HOLD);
  assign rec_load   = strobe_end && !rd_q;

  pbus_cfg_latch #(.SETUP_W(SETUP_W), .LOW_W(LOW_W), .TURN_W(TURN_W),
                   .RECOV_W(RECOV_W)) u_cfg (
    .clk(clk), .rst(rst), .accept(accept), .req_rd(req_rd),
    .cfg_setup(cfg_setup), .cfg_wr_low(cfg_wr_low), .cfg_wr_turn(cfg_wr_turn),
    .cfg_rd_low(cfg_rd_low), .cfg_rd_turn(cfg_rd_turn),
    .cfg_rd_recov(cfg_rd_recov),
    .rd_q(rd_q), .setup_q(setup_q), .low_q(low_q), .turn_q(turn_q),
    .recov_q(recov_q)
  );

  pbus_seq #(.SETUP_W(SETUP_W), .LOW_W(LOW_W), .TURN_W(TURN_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .rd_q(rd_q), .rec_zero(rec_zero),
    .setup_q(setup_q), .low_q(low_q), .turn_q(turn_q),
    .phase_q(phase_q), .phase_d(phase_d)
  );

  pbus_recov #(.RECOV_W(RECOV_W)) u_recov (
    .clk(clk), .rst(rst), .load(rec_load), .load_val(recov_q), .zero(rec_zero)
  );

  // All bus pins registered from the next phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_oe    <= 1'b0;
      bus_dc    <= 1'b0;
      bus_dout  <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      bus_cs_n <= !nxt_active;
      bus_wr_n <= !((phase_d == PH_STROBE) && !rd_q);
      bus_rd_n <= !((phase_d == PH_STROBE) && rd_q);
      bus_oe   <= nxt_active && !(accept ? req_rd : rd_q);
      rsp_done <= (phase_q == PH_HOLD);
      if (accept) begin
        bus_dc   <= req_dc;
        bus_dout <= req_wdata;
      end
      if (strobe_end && rd_q) rsp_rdata <= bus_din;
    end
  end

  // R5: strobes only inside chip select, and never both
  a_r5_wr_in_cs: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> !bus_cs_n);
  a_r5_rd_in_cs: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_cs_n);
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!bus_wr_n && !bus_rd_n));
  // R5: chip select only rises after both strobes were already high
  a_r5_strobe_first: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> ($past(bus_wr_n) && $past(bus_rd_n)));
  // R6: no drive while reading
  a_r6_read_no_drive: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_oe);
  // R6: data steady for the whole chip-select window
  a_r6_dout_steady: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(bus_cs_n) == 1'b0) |-> $stable(bus_dout));
  // R7: done coincides with chip-select release
  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $rose(bus_cs_n));
  // R9: read strobe falls only once recovery has expired
  a_r9_recov_gate: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) |-> $past(rec_zero));
  // R10: never ready during an access
  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> !req_ready);
endmodule

// File: tb/sim_pbus_master.sv
`timescale 1ns/1ps
module sim_pbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_rd = 1'b0, req_dc = 1'b0;
  logic        req_ready;
  logic [15:0] req_wdata = '0;
  logic [3:0]  cfg_setup = '0, cfg_wr_turn = '0, cfg_rd_turn = '0;
  logic [7:0]  cfg_wr_low = '0, cfg_rd_low = '0, cfg_rd_recov = '0;
  logic        rsp_done, bus_cs_n, bus_wr_n, bus_rd_n, bus_dc, bus_oe;
  logic [15:0] rsp_rdata, bus_dout;
  logic [15:0] bus_din = '0;

  always #2.5 clk = ~clk;

  pbus_master u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_dc(req_dc), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_wr_low(cfg_wr_low), .cfg_wr_turn(cfg_wr_turn),
    .cfg_rd_low(cfg_rd_low), .cfg_rd_turn(cfg_rd_turn),
    .cfg_rd_recov(cfg_rd_recov), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_dc(bus_dc), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  typedef struct {
    bit rd; bit dc; int wd; int s; int low; int turn; int rr; bit b2b;
  } txn_t;

  txn_t q[$];
  bit   first = 1'b1;

  function automatic int exp_low(input bit rd, input int wl, input int rl);
    return rd ? rl : wl;
  endfunction

  task automatic send(input bit rd, input bit dc, input int wd, input int s,
                      input int wl, input int wt, input int rl, input int rt,
                      input int rr);
    txn_t t;
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_dc = dc; req_wdata = 16'(wd);
    cfg_setup = 4'(s); cfg_wr_low = 8'(wl); cfg_wr_turn = 4'(wt);
    cfg_rd_low = 8'(rl); cfg_rd_turn = 4'(rt); cfg_rd_recov = 8'(rr);
    t.rd = rd; t.dc = dc; t.wd = wd & 16'hffff; t.s = s;
    t.low = exp_low(rd, wl, rl); t.turn = rd ? rt : wt; t.rr = rr;
    t.b2b = !first; first = 1'b0;
    q.push_back(t);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R2: scramble the timing inputs once the request is taken
    req_valid = 1'b0;
    cfg_setup = 4'($urandom); cfg_wr_low = 8'($urandom); cfg_wr_turn = 4'($urandom);
    cfg_rd_low = 8'($urandom); cfg_rd_turn = 4'($urandom); cfg_rd_recov = 8'($urandom);
  endtask

  // Bus monitor: everything on falling edges
  txn_t        cur;
  bit          pcs = 1'b1, pwr = 1'b1, prd = 1'b1, last_wr = 1'b0;
  int          setup_c = 0, low_c = 0, hold_c = 0, hi_c = 0, since = 0;
  int          last_rr = 0, last_turn = 0;
  logic [15:0] exp_rd = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (pcs && !bus_cs_n) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected access", 0, 1);
        else cur = q.pop_front();
        if (cur.b2b) chk(hi_c == last_turn + 1, "R8 turnaround", hi_c, last_turn + 1);
        setup_c = 0; low_c = 0; hold_c = 0;
        exp_rd  = 16'($urandom);
        bus_din = exp_rd ^ 16'ha5c3;
      end
      if (!bus_cs_n) begin
        chk(req_ready == 1'b0, "R10 ready", int'(req_ready), 0);
        chk(bus_dc == cur.dc, "R2 dc", int'(bus_dc), int'(cur.dc));
        if (cur.rd) begin
          chk(bus_oe == 1'b0, "R6 oe read", int'(bus_oe), 0);
          chk(bus_wr_n == 1'b1, "R5 wrong strobe", int'(bus_wr_n), 1);
        end else begin
          chk(bus_oe == 1'b1, "R6 oe write", int'(bus_oe), 1);
          chk(int'(bus_dout) == cur.wd, "R6 dout", int'(bus_dout), cur.wd);
          chk(bus_rd_n == 1'b1, "R5 wrong strobe", int'(bus_rd_n), 1);
        end
        chk(rsp_done == 1'b0, "R7 early done", int'(rsp_done), 0);
        if (!bus_wr_n || !bus_rd_n) begin
          if (low_c == 0 && cur.rd && last_wr) begin
            chk(since >= last_rr + 1, "R9 recovery min", since, last_rr + 1);
            if (setup_c > cur.s + 1)
              chk(since == last_rr + 1, "R9 recovery exact", since, last_rr + 1);
          end
          low_c++;
        end else if (low_c == 0) setup_c++;
        else hold_c++;
        if (cur.rd && !bus_rd_n && low_c == cur.low + 1) bus_din = exp_rd;
        else bus_din = exp_rd ^ 16'ha5c3;
      end else begin
        chk(bus_wr_n && bus_rd_n, "R5 strobe outside cs", int'({bus_wr_n, bus_rd_n}), 3);
        chk(bus_oe == 1'b0, "R6 oe idle", int'(bus_oe), 0);
        if (!pcs) begin
          chk(rsp_done == 1'b1, "R7 done", int'(rsp_done), 1);
          if (cur.rd) chk(rsp_rdata == exp_rd, "R7 rdata", int'(rsp_rdata), int'(exp_rd));
          chk(hold_c == 1, "R5 hold", hold_c, 1);
          chk(low_c == cur.low + 1, "R4 strobe width", low_c, cur.low + 1);
          if (cur.rd && last_wr)
            chk(setup_c >= cur.s + 1, "R3 setup min", setup_c, cur.s + 1);
          else
            chk(setup_c == cur.s + 1, "R3 setup", setup_c, cur.s + 1);
          last_turn = cur.turn;
          hi_c = 1;
          if (!cur.rd) begin last_wr = 1'b1; last_rr = cur.rr; end
          else last_wr = 1'b0;
        end else begin
          chk(rsp_done == 1'b0, "R7 stray done", int'(rsp_done), 0);
          hi_c++;
        end
      end
      if (!bus_wr_n) since = 0; else since++;
      pcs = bus_cs_n; pwr = bus_wr_n; prd = bus_rd_n;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd8080));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(bus_cs_n && bus_wr_n && bus_rd_n, "R1 strobes idle", int'({bus_cs_n, bus_wr_n, bus_rd_n}), 7);
    chk(!bus_oe && !rsp_done, "R1 oe/done", int'({bus_oe, rsp_done}), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(bus_cs_n && req_ready, "R1 after reset", int'({bus_cs_n, req_ready}), 3);
    // minimum timings, write then read with no recovery
    send(0, 0, 16'h1234, 0, 0, 0, 0, 0, 0);
    send(1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R9: long recovery forces an exact gap
    send(0, 1, 16'hbeef, 1, 2, 0, 3, 0, 40);
    send(1, 0, 0, 0, 0, 0, 4, 2, 0);
    // R4: extreme widths
    send(0, 0, 16'h8001, 15, 255, 15, 0, 0, 0);
    send(1, 1, 0, 3, 0, 0, 255, 15, 0);
    send(1, 0, 0, 0, 0, 0, 1, 0, 0);
    // walking ones on writes
    for (int i = 0; i < 16; i++) send(0, i[0], 1 << i, i % 3, i % 5, i % 4, 0, 0, 0);
    // constrained random mix
    for (int i = 0; i < 250; i++) begin
      bit rd = 1'($urandom);
      send(rd, 1'($urandom), int'($urandom & 32'hffff), int'($urandom % 16),
           (($urandom % 10) == 0) ? 255 : int'($urandom % 24), int'($urandom % 16),
           (($urandom % 10) == 0) ? 200 : int'($urandom % 24), int'($urandom % 16),
           int'($urandom % 60));
    end
    repeat (300) @(negedge clk);
    chk(q.size() == 0, "R2 all accesses issued", q.size(), 0);
    chk(bus_cs_n && req_ready, "R1 idle at end", int'({bus_cs_n, req_ready}), 3);
    finish_run();
  end
endmodule